// File: doc/BRIEF.md
# Segment LCD Frame Timing Sequencer

This block produces the frame-level timing for a multiplexed segment display. It runs from a prescaled tick strobe. Each common is driven for one phase of `PHASE_TICKS` ticks, and one frame walks through every active common in turn. After every second frame it can add a programmable number of idle phases. Within each phase it opens a drive window that is a programmable number of ticks long. It also runs a slow blink gate that forces a chosen group of pixels off. The downstream segment and common drivers use `com_idx_o`, `com_en_o`, `pon_o` and the two kill outputs to decide what reaches the glass.

Software sets the number of commons and raises the enable. The status output rises at once. If the enable is dropped, the status stays high until the frame that is on screen has finished. The blink, drive-window and idle-phase settings are copied at each frame start. The common count is copied only while the sequencer is idle.

Top module: `lcd_frame_seq`

## Requirements
- R1: `ens_o` is 0 after reset and is 1 in the same cycle that `enable_i` is 1, before any clock edge.
- R2: The common count follows `duty_i`: 0→1, 1→2, 2→3, 3→4, 4..7→8. Each phase lasts `PHASE_TICKS` ticks. `com_idx_o` steps 0,1,…,count-1. `sof_o` pulses for one cycle, with `com_idx_o`=0, at the start of each frame.
- R3: In each driven phase, `pon_o` is high for the first `pon_len_i` ticks (0 to 7). A value of 0 gives no pulse.
- R4: After each odd frame (the second, fourth, … since start), `dead_len_i` idle phases are inserted. During these phases `com_en_o` and `pon_o` are 0 and `com_idx_o` holds. A value of 0 inserts nothing.
- R5: When `enable_i` falls, the current frame runs to its end. Then `ens_o` and `com_en_o` drop together, with no further `sof_o`.
- R6: The blink gate toggles every 2^(`blink_div_i`+2) frames, which gives a blink period of 2^(`blink_div_i`+3) frames. It is high from start. In mode 3, while the gate is low, `kill_seg0_o` and `kill_rest_o` are both 1.
- R7: Blink mode 1 kills segment 0 only on common 0. Mode 2 kills segment 0 on every common. Neither mode sets `kill_rest_o`. Mode 0 kills nothing.
- R8: A change to `duty_i` while the sequencer is running has no effect on frame length.
- R9: The sequencer advances only on cycles where `tick_i` is 1.
- R10: A change to `pon_len_i`, `dead_len_i`, `blink_mode_i` or `blink_div_i` takes effect at the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Prescaled tick strobe |
| enable_i | input | 1 | Display enable |
| duty_i | input | 3 | Common count code |
| pon_len_i | input | 3 | Drive window length in ticks |
| dead_len_i | input | 3 | Idle phases after each frame pair |
| blink_mode_i | input | 2 | 0 off, 1 seg0/com0, 2 seg0/all coms, 3 all pixels |
| blink_div_i | input | 3 | Blink period code, 8 to 1024 frames |
| ens_o | output | 1 | Enabled status |
| com_en_o | output | 1 | A common is being driven |
| com_idx_o | output | 3 | Index of the active common |
| sof_o | output | 1 | Start-of-frame strobe |
| pon_o | output | 1 | Drive window |
| blink_gate_o | output | 1 | Blink gate level (1 = visible) |
| kill_seg0_o | output | 1 | Force segment 0 off on this common |
| kill_rest_o | output | 1 | Force all other segments off |

## Verification
The end of a frame can coincide with a falling enable, so the stop decision and the dead-time or next-frame decision fall on the same tick. The bench drops the enable part-way through a four-common frame and counts the cycles until the status clears. It expects the clear on the exact edge that ends the frame, with no new start strobe. A second coincidence is a blink toggle that lands on a frame start. It is judged by sampling the kill outputs in the frame just before and the frame just after the computed toggle frame.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  localparam int unsigned CFG_W  = 3;
  localparam int unsigned IDX_W  = 3;
  localparam int unsigned NCOM_W = IDX_W + 1;
  localparam int unsigned BLK_W  = 10;

  typedef enum logic [1:0] {
    BLK_OFF      = 2'd0,
    BLK_S0_C0    = 2'd1,
    BLK_S0_ALLC  = 2'd2,
    BLK_ALL      = 2'd3
  } blink_mode_e;

  function automatic logic [NCOM_W-1:0] duty_coms(input logic [CFG_W-1:0] d);
    case (d)
      3'd0:    return NCOM_W'(1);
      3'd1:    return NCOM_W'(2);
      3'd2:    return NCOM_W'(3);
      3'd3:    return NCOM_W'(4);
      default: return NCOM_W'(8);
    endcase
  endfunction
endpackage

// File: rtl/lcd_phase_ctrl.sv
module lcd_phase_ctrl
  import lcd_seq_pkg::*;
#(
  parameter int unsigned PHASE_TICKS = 8,
  localparam int unsigned TW = (PHASE_TICKS > 1) ? $clog2(PHASE_TICKS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             enable_i,
  input  logic [CFG_W-1:0] duty_i,
  input  logic [CFG_W-1:0] pon_len_i,
  input  logic [CFG_W-1:0] dead_len_i,
  input  logic [1:0]       blink_mode_i,
  input  logic [CFG_W-1:0] blink_div_i,
  output logic             run_o,
  output logic             active_o,
  output logic [IDX_W-1:0] phase_o,
  output logic [TW-1:0]    tcnt_o,
  output logic             sof_o,
  output logic             first_o,
  output logic             adv_o,
  output logic [CFG_W-1:0] pon_o,
  output blink_mode_e      bmode_o,
  output logic [CFG_W-1:0] bdiv_o
);
  logic              run_q, dead_q, odd_q, sof_q;
  logic [TW-1:0]     tcnt_q;
  logic [IDX_W-1:0]  phase_q;
  logic [CFG_W-1:0]  dcnt_q, dlen_q, pon_q, bdiv_q;
  logic [NCOM_W-1:0] ncom_q;
  blink_mode_e       bmode_q;

  logic phase_end, last_com, start_idle, frame_done, dead_done;
  logic go_dead, next_frame, stop, restart;

  always_comb begin
    phase_end  = tick_i && (tcnt_q == TW'(PHASE_TICKS - 1));
    last_com   = ({1'b0, phase_q} + NCOM_W'(1)) == ncom_q;
    start_idle = !run_q && enable_i;
    frame_done = run_q && !dead_q && phase_end && last_com;
    dead_done  = run_q && dead_q && phase_end && (dcnt_q == dlen_q - CFG_W'(1));
    go_dead    = frame_done && enable_i && odd_q && (dlen_q != '0);
    next_frame = (frame_done || dead_done) && enable_i && !go_dead;
    stop       = (frame_done || dead_done) && !enable_i;
    restart    = start_idle || next_frame;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      dead_q  <= 1'b0;
      odd_q   <= 1'b0;
      sof_q   <= 1'b0;
      tcnt_q  <= '0;
      phase_q <= '0;
      dcnt_q  <= '0;
      dlen_q  <= '0;
      pon_q   <= '0;
      bdiv_q  <= '0;
      bmode_q <= BLK_OFF;
      ncom_q  <= NCOM_W'(1);
    end else begin
      sof_q <= restart;
      if (!run_q) ncom_q <= duty_coms(duty_i);
      if (restart) begin
        run_q   <= 1'b1;
        dead_q  <= 1'b0;
        odd_q   <= start_idle ? 1'b0 : (frame_done ? ~odd_q : 1'b0);
        tcnt_q  <= '0;
        phase_q <= '0;
        pon_q   <= pon_len_i;
        dlen_q  <= dead_len_i;
        bdiv_q  <= blink_div_i;
        bmode_q <= blink_mode_e'(blink_mode_i);
      end else if (stop) begin
        run_q   <= 1'b0;
        dead_q  <= 1'b0;
        odd_q   <= 1'b0;
        tcnt_q  <= '0;
        phase_q <= '0;
      end else if (go_dead) begin
        dead_q <= 1'b1;
        odd_q  <= 1'b0;
        dcnt_q <= '0;
        tcnt_q <= '0;
      end else if (run_q && tick_i) begin
        if (phase_end) begin
          tcnt_q <= '0;
          if (dead_q) dcnt_q <= dcnt_q + CFG_W'(1);
          else        phase_q <= phase_q + IDX_W'(1);
        end else begin
          tcnt_q <= tcnt_q + TW'(1);
        end
      end
    end
  end

  assign run_o    = run_q;
  assign active_o = run_q && !dead_q;
  assign phase_o  = phase_q;
  assign tcnt_o   = tcnt_q;
  assign sof_o    = sof_q;
  assign first_o  = start_idle;
  assign adv_o    = next_frame;
  assign pon_o    = pon_q;
  assign bmode_o  = bmode_q;
  assign bdiv_o   = bdiv_q;
endmodule

// File: rtl/lcd_blink_gate.sv
module lcd_blink_gate
  import lcd_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             first_i,
  input  logic             adv_i,
  input  logic [CFG_W-1:0] div_i,
  output logic             gate_o
);
  logic [BLK_W-1:0] cnt_q, half_m1;
  logic             gate_q;

  // half period in frames: 4 << div
  assign half_m1 = (BLK_W'(4) << div_i) - BLK_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      gate_q <= 1'b1;
    end else if (first_i) begin
      cnt_q  <= '0;
      gate_q <= 1'b1;
    end else if (adv_i) begin
      if (cnt_q == half_m1) begin
        cnt_q  <= '0;
        gate_q <= ~gate_q;
      end else begin
        cnt_q <= cnt_q + BLK_W'(1);
      end
    end
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/lcd_pix_mask.sv
module lcd_pix_mask
  import lcd_seq_pkg::*;
#(
  parameter int unsigned TW = 3
) (
  input  logic             active_i,
  input  logic             gate_i,
  input  blink_mode_e      mode_i,
  input  logic [IDX_W-1:0] phase_i,
  input  logic [TW-1:0]    tcnt_i,
  input  logic [CFG_W-1:0] pon_len_i,
  output logic             pon_o,
  output logic             kill_seg0_o,
  output logic             kill_rest_o
);
  logic blank;

  always_comb begin
    blank = active_i && !gate_i;
    pon_o = active_i && (32'(tcnt_i) < 32'(pon_len_i));
    unique case (mode_i)
      BLK_S0_C0:   kill_seg0_o = blank && (phase_i == '0);
      BLK_S0_ALLC: kill_seg0_o = blank;
      BLK_ALL:     kill_seg0_o = blank;
      default:     kill_seg0_o = 1'b0;
    endcase
    kill_rest_o = blank && (mode_i == BLK_ALL);
  end
endmodule

// File: rtl/lcd_frame_seq.sv
module lcd_frame_seq
  import lcd_seq_pkg::*;
#(
  parameter int unsigned PHASE_TICKS = 8,
  localparam int unsigned TW = (PHASE_TICKS > 1) ? $clog2(PHASE_TICKS) : 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       enable_i,
  input  logic [2:0] duty_i,
  input  logic [2:0] pon_len_i,
  input  logic [2:0] dead_len_i,
  input  logic [1:0] blink_mode_i,
  input  logic [2:0] blink_div_i,
  output logic       ens_o,
  output logic       com_en_o,
  output logic [2:0] com_idx_o,
  output logic       sof_o,
  output logic       pon_o,
  output logic       blink_gate_o,
  output logic       kill_seg0_o,
  output logic       kill_rest_o
);
  logic             run, active, first, adv;
  logic [IDX_W-1:0] phase;
  logic [TW-1:0]    tcnt;
  logic [CFG_W-1:0] pon_len_q, bdiv_q;
  blink_mode_e      bmode_q;
  logic             gate;

  lcd_phase_ctrl #(.PHASE_TICKS(PHASE_TICKS)) u_ctrl (
    .clk_i, .rst_ni, .tick_i, .enable_i, .duty_i, .pon_len_i, .dead_len_i,
    .blink_mode_i, .blink_div_i,
    .run_o(run), .active_o(active), .phase_o(phase), .tcnt_o(tcnt),
    .sof_o(sof_o), .first_o(first), .adv_o(adv), .pon_o(pon_len_q),
    .bmode_o(bmode_q), .bdiv_o(bdiv_q)
  );

  lcd_blink_gate u_blink (
    .clk_i, .rst_ni, .first_i(first), .adv_i(adv), .div_i(bdiv_q), .gate_o(gate)
  );

  lcd_pix_mask #(.TW(TW)) u_mask (
    .active_i(active), .gate_i(gate), .mode_i(bmode_q), .phase_i(phase),
    .tcnt_i(tcnt), .pon_len_i(pon_len_q),
    .pon_o(pon_o), .kill_seg0_o(kill_seg0_o), .kill_rest_o(kill_rest_o)
  );

  assign ens_o        = run || enable_i;
  assign com_en_o     = active;
  assign com_idx_o    = phase;
  assign blink_gate_o = gate;
endmodule

// File: rtl/lcd_frame_seq_chk.sv
module lcd_frame_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       enable_i,
  input logic       ens_o,
  input logic       com_en_o,
  input logic [2:0] com_idx_o,
  input logic       sof_o,
  input logic       pon_o,
  input logic       kill_seg0_o,
  input logic       kill_rest_o
);
  a_r1_ens_follows_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i |-> ens_o);
  a_r2_sof_at_com0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> (com_idx_o == 3'd0) && com_en_o);
  a_r3_pon_when_driven: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pon_o |-> com_en_o);
  a_r5_drive_implies_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    com_en_o |-> ens_o);
  a_r5_no_sof_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ens_o |-> !sof_o && !com_en_o);
  a_r6_rest_implies_seg0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_rest_o |-> kill_seg0_o);
  a_r9_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(com_idx_o));
endmodule

bind lcd_frame_seq lcd_frame_seq_chk u_chk (.*);

// File: tb/lcd_frame_seq_tb.sv
module lcd_frame_seq_tb;
  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       tick_i = 1'b1, enable_i = 1'b0;
  logic [2:0] duty_i = '0, pon_len_i = '0, dead_len_i = '0, blink_div_i = '0;
  logic [1:0] blink_mode_i = '0;
  logic       ens_o, com_en_o, sof_o, pon_o, blink_gate_o, kill_seg0_o, kill_rest_o;
  logic [2:0] com_idx_o;
  logic       slow_tick = 1'b0;
  int checks = 0, errors = 0;
  bit done = 0;

  lcd_frame_seq u_dut (.*, .clk_i(clk));

  always #2.5 clk = ~clk;
  always @(negedge clk) tick_i <= slow_tick ? ~tick_i : 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sync_sof();
    do @(negedge clk); while (!sof_o);
  endtask

  task automatic gap(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!sof_o);
  endtask

  task automatic nsofs(input int k);
    for (int i = 0; i < k; i++) begin
      do @(negedge clk); while (!sof_o);
    end
  endtask

  task automatic start(input int duty, input int pon, input int dead, input int mode, input int div);
    @(negedge clk);
    duty_i = 3'(duty); pon_len_i = 3'(pon); dead_len_i = 3'(dead);
    blink_mode_i = 2'(mode); blink_div_i = 3'(div);
    enable_i = 1'b1;
  endtask

  task automatic stop();
    @(negedge clk);
    enable_i = 1'b0;
    for (int i = 0; i < 2000 && ens_o; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!ens_o && !com_en_o && !sof_o && !pon_o && !kill_seg0_o && !kill_rest_o,
        "R1 reset outputs", int'(ens_o), 0);
    @(negedge clk);
    enable_i = 1'b1; #1;
    chk(ens_o, "R1 immediate status", int'(ens_o), 1);
    enable_i = 1'b0;
  endtask

  task automatic t_phases();
    int n;
    start(3, 0, 0, 0, 0);
    sync_sof();
    for (int k = 0; k < 4; k++) begin
      chk(com_idx_o == 3'(k), "R2 com index", int'(com_idx_o), k);
      repeat (8) @(negedge clk);
    end
    chk(sof_o, "R2 sof at frame start", int'(sof_o), 1);
    gap(n); chk(n == 32, "R2 four-common frame", n, 32);
    stop();
    start(4, 0, 0, 0, 0);
    sync_sof(); gap(n); chk(n == 64, "R2 eight-common frame", n, 64);
    stop();
  endtask

  task automatic t_pon(input int p);
    int c = 0;
    start(0, p, 0, 0, 0);
    sync_sof();
    for (int i = 0; i < 8; i++) begin c += int'(pon_o); @(negedge clk); end
    chk(c == p, "R3 pulse-on width", c, p);
    stop();
  endtask

  task automatic t_dead();
    int n;
    start(0, 7, 2, 0, 0);
    sync_sof();
    gap(n); chk(n == 8, "R4 even to odd frame", n, 8);
    repeat (8) @(negedge clk);
    chk(!com_en_o && !pon_o && ens_o, "R4 quiet in dead phase", int'(com_en_o), 0);
    chk(com_idx_o == 3'd0, "R4 index held", int'(com_idx_o), 0);
    gap(n); chk(n == 16, "R4 dead remainder", n, 16);
    gap(n); chk(n == 8, "R4 no dead after even", n, 8);
    stop();
    start(0, 0, 0, 0, 0);
    sync_sof(); gap(n); gap(n); chk(n == 8, "R4 zero dead", n, 8);
    stop();
  endtask

  task automatic t_disable();
    int k = 0;
    bit sof_seen = 0;
    start(3, 0, 0, 0, 0);
    sync_sof();
    repeat (5) @(negedge clk);
    enable_i = 1'b0; #1;
    chk(ens_o, "R5 status held after drop", int'(ens_o), 1);
    while (ens_o && k < 100) begin
      @(negedge clk); k++;
      if (sof_o) sof_seen = 1;
    end
    chk(k == 27, "R5 clear at frame end", k, 27);
    chk(!com_en_o && !sof_seen, "R5 no drive after stop", int'(sof_seen), 0);
  endtask

  task automatic t_blink_all(input int div);
    int h = 4 << div;
    start(0, 0, 0, 3, div);
    sync_sof();
    nsofs(h - 1);
    chk(!kill_rest_o && blink_gate_o, "R6 visible before toggle", int'(kill_rest_o), 0);
    nsofs(1);
    chk(kill_rest_o && kill_seg0_o, "R6 masked after toggle", int'(kill_rest_o), 1);
    nsofs(h);
    chk(!kill_rest_o && !kill_seg0_o, "R6 visible again", int'(kill_rest_o), 0);
    stop();
  endtask

  task automatic t_blink_sel(input int mode);
    start(1, 0, 0, mode, 0);
    sync_sof();
    nsofs(4);
    chk(kill_seg0_o == (mode != 0) && !kill_rest_o, "R7 com0 mask",
        int'(kill_seg0_o), int'(mode != 0));
    repeat (8) @(negedge clk);
    chk(kill_seg0_o == (mode == 2) && !kill_rest_o, "R7 com1 mask",
        int'(kill_seg0_o), int'(mode == 2));
    stop();
  endtask

  task automatic t_duty_hold();
    int n;
    start(1, 0, 0, 0, 0);
    sync_sof();
    duty_i = 3'd4;
    gap(n); chk(n == 16, "R8 duty change ignored", n, 16);
    gap(n); chk(n == 16, "R8 still ignored", n, 16);
    stop();
  endtask

  task automatic t_tick();
    int n;
    slow_tick = 1'b1;
    start(0, 0, 0, 0, 0);
    sync_sof(); gap(n); gap(n);
    chk(n == 16, "R9 half-rate tick", n, 16);
    stop();
    slow_tick = 1'b0;
  endtask

  task automatic t_cfg_frame();
    int c = 0;
    start(1, 2, 0, 0, 0);
    sync_sof();
    pon_len_i = 3'd6;
    for (int i = 0; i < 16; i++) begin c += int'(pon_o); @(negedge clk); end
    chk(c == 4, "R10 old pulse-on kept", c, 4);
    chk(sof_o, "R10 next frame start", int'(sof_o), 1);
    c = 0;
    for (int i = 0; i < 8; i++) begin c += int'(pon_o); @(negedge clk); end
    chk(c == 6, "R10 new pulse-on applied", c, 6);
    stop();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    stop();
    t_phases();
    t_pon(0); t_pon(3); t_pon(7);
    t_dead();
    t_disable();
    t_blink_all(0); t_blink_all(1);
    t_blink_sel(0); t_blink_sel(1); t_blink_sel(2);
    t_duty_hold();
    t_tick();
    t_cfg_frame();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule